// File: doc/BRIEF.md
# SPI Master with Start Inhibit and Software-Held Select

This block is a single-byte SPI master. It derives the serial clock from the system clock by counting a programmable number of system clocks per half period, and it supports every combination of clock polarity and clock phase. A transfer begins once a transmit byte is waiting, the block is enabled, at least one select line is requested, and the start-inhibit control is clear. Software can therefore hold transfers off while it pulls a slave select low by hand and loads data, and then release the master.

Slave select can be timed by the block (automatic mode) or follow the select vector directly (manual mode). In manual mode software decides how long the slave stays selected and how many bytes it receives, and the serial timing within each byte is unchanged. When the last serial clock cycle of a byte ends, all status flags and both interrupt flags change together on one system clock edge, and busy falls on that same edge. With clock phase 1 the end of the last cycle has no serial clock transition, so an internal half-period count supplies that event. If every select line is released during a transfer, the transfer is abandoned and its bit count is cleared.

Top module: `spi_inhibit_master`

## Requirements
- R1: After reset, status_o is 4'b0101 (bit 0 receive empty and bit 2 transmit empty set, bit 1 receive full and bit 3 transmit full clear), irq_o is 0, busy_o is 0, every ss_no line is high and sck_o equals ctrl_cpol_i.
- R2: While ctrl_inhibit_i is 1, no transfer starts: busy_o stays 0, ss_no stays all high in automatic mode and sck_o stays at its idle level, even with a transmit byte waiting.
- R3: A tx_wr_i pulse while status bit 3 is clear stores tx_data_i, sets bit 3 and clears bit 2. A tx_wr_i pulse while bit 3 is set is ignored, and the stored byte is the one sent.
- R4: Each transfer moves 8 bits, most significant bit first, in both directions. With ctrl_cpha_i = 0 both sides sample on the first (leading) edge of each clock cycle. With ctrl_cpha_i = 1 they sample on the second (trailing) edge. sck_o rests at ctrl_cpol_i, and mosi_o changes only together with an sck_o edge while busy.
- R5: A half period of sck_o lasts max(div_i, 1) system clocks, using the div_i value seen when the transfer starts, and every transfer makes exactly 16 sck_o edges.
- R6: In automatic mode the lines of ss_no whose ss_vec_i bits are 0 go low on the start edge, one half period before the first sck_o edge. They go back high one half period after the completion edge. All lines are high when idle.
- R7: In manual mode, while enabled, ss_no equals ss_vec_i at all times, including between bytes, and each byte is sent with the same clock timing as in automatic mode.
- R8: With ctrl_cpha_i = 0 the completion edge is the 16th sck_o edge. With ctrl_cpha_i = 1 it comes one half period after the 16th edge.
- R9: On the completion edge, together: busy_o falls, rx_data_o takes the received byte, status becomes 4'b0110, and irq_o bit 0 (byte received) and bit 1 (transfer done) are set.
- R10: A rx_rd_i pulse sets status bit 0 and clears bit 1. irq_clr_i clears the irq_o bits written as one. A completion on the same edge wins over both.
- R11: If ss_vec_i becomes all ones during a transfer, the next edge returns the block to idle with busy_o low and sck_o idle. Status, irq_o and rx_data_o are unchanged. The byte stays pending, and the next transfer starts from bit zero.
- R12: busy_o is high from the start edge until the completion edge: 16 half periods for ctrl_cpha_i = 0 and 17 for ctrl_cpha_i = 1.
- R13: With ctrl_enable_i low, every ss_no line is high, no transfer starts, and a running transfer is abandoned as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_enable_i | input | 1 | Master enable |
| ctrl_inhibit_i | input | 1 | Holds off the start of transfers |
| ctrl_manual_ss_i | input | 1 | 1: ss_no follows ss_vec_i directly |
| ctrl_cpol_i | input | 1 | Idle level of sck_o |
| ctrl_cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| div_i | input | DIV_W | Half period in system clocks (0 acts as 1) |
| ss_vec_i | input | NUM_SS | Requested select pattern, active low |
| tx_data_i | input | DATA_W | Transmit byte |
| tx_wr_i | input | 1 | Store tx_data_i when the transmit register is empty |
| rx_rd_i | input | 1 | Mark the received byte as consumed |
| irq_clr_i | input | 2 | Write-one-to-clear for irq_o |
| miso_i | input | 1 | Serial data from the slave |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| ss_no | output | NUM_SS | Slave select lines, active low |
| rx_data_o | output | DATA_W | Last received byte |
| busy_o | output | 1 | Transfer in progress |
| status_o | output | 4 | bit0 rx empty, bit1 rx full, bit2 tx empty, bit3 tx full |
| irq_o | output | 2 | bit0 byte received, bit1 transfer done |

## Verification
The bench loads a byte while the inhibit control is set and then writes a second byte into the full register. A design that leaked the inhibit would select the slave early, and one that took the second write would send the wrong byte. Every clock mode is run against a behavioural slave with several divider values, including zero. On each byte the bench measures the lead time from select to first edge, the number of edges, the gap from the last edge to completion and the select tail. A phase-1 design that finished on its last edge would show up here, as would one that let its status flags drift across edges. Transfers are abandoned mid-byte both by releasing every select and by clearing enable. The bench then checks that status stayed put and that the restarted byte arrives whole, which catches a bit counter that is not reset.

// File: rtl/spi_inh_pkg.sv
package spi_inh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_TRAIL  = 2'd2
  } xfer_state_e;

  localparam int ST_RX_EMPTY = 0;
  localparam int ST_RX_FULL  = 1;
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_TX_FULL  = 3;

  localparam int IRQ_RX   = 0;
  localparam int IRQ_DONE = 1;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == (half_i - DIV_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] sh_q;
  logic              samp_q;

  assign mosi_o   = sh_q[DATA_W-1];
  // last sampled bit is appended without a final shift
  assign result_o = {sh_q[DATA_W-2:0], samp_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      samp_q <= 1'b0;
    end else begin
      if (load_i)       sh_q <= load_data_i;
      else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], samp_q};
      if (sample_i)     samp_q <= miso_i;
    end
  end
endmodule

// File: rtl/spi_status_unit.sv
module spi_status_unit
  import spi_inh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  input  logic [1:0]        irq_clr_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] tx_hold_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [3:0]        status_o,
  output logic [1:0]        irq_o
);
  logic tx_full_q, rx_full_q;
  logic [1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
      irq_q     <= '0;
      tx_hold_o <= '0;
      rx_data_o <= '0;
    end else begin
      if (done_i)                      tx_full_q <= 1'b0;
      else if (tx_wr_i && !tx_full_q)  tx_full_q <= 1'b1;
      if (tx_wr_i && !tx_full_q)       tx_hold_o <= tx_data_i;

      if (done_i) begin
        rx_full_q <= 1'b1;
        rx_data_o <= result_i;
      end else if (rx_rd_i) begin
        rx_full_q <= 1'b0;
      end

      // completion wins over a same-edge clear
      if (done_i) irq_q <= 2'b11;
      else        irq_q <= irq_q & ~irq_clr_i;
    end
  end

  always_comb begin
    status_o[ST_RX_EMPTY] = !rx_full_q;
    status_o[ST_RX_FULL]  = rx_full_q;
    status_o[ST_TX_EMPTY] = !tx_full_q;
    status_o[ST_TX_FULL]  = tx_full_q;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/spi_inhibit_master.sv
module spi_inhibit_master
  import spi_inh_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int NUM_SS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_enable_i,
  input  logic              ctrl_inhibit_i,
  input  logic              ctrl_manual_ss_i,
  input  logic              ctrl_cpol_i,
  input  logic              ctrl_cpha_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [NUM_SS-1:0] ss_vec_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_wr_i,
  input  logic              rx_rd_i,
  input  logic [1:0]        irq_clr_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [NUM_SS-1:0] ss_no,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic [3:0]        status_o,
  output logic [1:0]        irq_o
);
  localparam int EDGE_N = 2 * DATA_W;
  localparam int CNT_W  = $clog2(EDGE_N + 2);
  localparam logic [CNT_W-1:0] K_LAST = CNT_W'(EDGE_N);
  localparam logic [CNT_W-1:0] K_XTRA = CNT_W'(EDGE_N + 1);
  localparam logic [CNT_W-1:0] K_3    = CNT_W'(3);

  xfer_state_e       state_q, state_d;
  logic [CNT_W-1:0]  k_q, k_now, k_end;
  logic              phase_q, cpha_q;
  logic [DIV_W-1:0]  half_q;
  logic              tick, start, abort, ss_all_off;
  logic              edge_ev, sample_ev, shift_ev, done, k_odd;
  logic [DATA_W-1:0] tx_hold, result;

  assign ss_all_off = &ss_vec_i;
  assign start = (state_q == ST_IDLE) && ctrl_enable_i && !ctrl_inhibit_i
                 && status_o[ST_TX_FULL] && !ss_all_off;
  assign abort = (state_q != ST_IDLE) && (!ctrl_enable_i || ss_all_off);

  // k_now numbers the half-period boundaries since start, from 1
  assign k_now = k_q + 1'b1;
  assign k_odd = k_now[0];
  // phase 1 has no clock edge at its end: one extra half period marks it
  assign k_end = cpha_q ? K_XTRA : K_LAST;

  assign edge_ev   = (state_q == ST_ACTIVE) && tick && !abort && (k_now <= K_LAST);
  assign done      = (state_q == ST_ACTIVE) && tick && !abort && (k_now == k_end);
  assign sample_ev = edge_ev && (cpha_q ? !k_odd : k_odd);
  assign shift_ev  = edge_ev && (cpha_q ? (k_odd && k_now >= K_3)
                                        : (!k_odd && k_now < K_LAST));

  spi_half_timer #(.DIV_W(DIV_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .half_i (half_q),
    .tick_o (tick)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_ACTIVE;
      ST_ACTIVE: if (done)  state_d = ST_TRAIL;
      ST_TRAIL:  if (tick)  state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
    if (abort) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      phase_q <= 1'b0;
      cpha_q  <= 1'b0;
      half_q  <= DIV_W'(1);
    end else begin
      state_q <= state_d;
      if (start) begin
        k_q     <= '0;
        phase_q <= 1'b0;
        cpha_q  <= ctrl_cpha_i;
        half_q  <= (div_i == '0) ? DIV_W'(1) : div_i;
      end else if (abort) begin
        k_q     <= '0;
        phase_q <= 1'b0;
      end else if ((state_q == ST_ACTIVE) && tick) begin
        k_q <= k_now;
        if (edge_ev) phase_q <= !phase_q;
      end
    end
  end

  spi_shift_unit #(.DATA_W(DATA_W)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .load_data_i (tx_hold),
    .sample_i    (sample_ev),
    .shift_i     (shift_ev),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .result_o    (result)
  );

  spi_status_unit #(.DATA_W(DATA_W)) i_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_wr_i   (tx_wr_i),
    .tx_data_i (tx_data_i),
    .rx_rd_i   (rx_rd_i),
    .irq_clr_i (irq_clr_i),
    .done_i    (done),
    .result_i  (result),
    .tx_hold_o (tx_hold),
    .rx_data_o (rx_data_o),
    .status_o  (status_o),
    .irq_o     (irq_o)
  );

  assign sck_o  = ctrl_cpol_i ^ phase_q;
  assign busy_o = (state_q == ST_ACTIVE);

  for (genvar g = 0; g < NUM_SS; g++) begin : g_ss
    assign ss_no[g] = !ctrl_enable_i   ? 1'b1 :
                      ctrl_manual_ss_i ? ss_vec_i[g] :
                      (state_q == ST_IDLE) ? 1'b1 : ss_vec_i[g];
  end
endmodule

// File: rtl/spi_inhibit_master_chk.sv
module spi_inhibit_master_chk #(
  parameter int NUM_SS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_enable_i,
  input logic              ctrl_inhibit_i,
  input logic              ctrl_cpol_i,
  input logic [NUM_SS-1:0] ss_vec_i,
  input logic              rx_rd_i,
  input logic              sck_o,
  input logic              mosi_o,
  input logic [NUM_SS-1:0] ss_no,
  input logic              busy_o,
  input logic [3:0]        status_o,
  input logic [1:0]        irq_o
);
  assert_inhibit_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && ctrl_inhibit_i) |=> !busy_o);

  assert_sck_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sck_o == ctrl_cpol_i));

  assert_mosi_with_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && $stable(sck_o) && $stable(ctrl_cpol_i)) |-> $stable(mosi_o));

  assert_start_selects_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && !(&ss_vec_i)) |-> !(&ss_no));

  assert_done_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $past(ctrl_enable_i) && !$past(&ss_vec_i))
      |-> (status_o == 4'b0110 && irq_o == 2'b11));

  assert_rx_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && !busy_o) |=> (!status_o[1] && status_o[0]));

  assert_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && &ss_vec_i) |=> !busy_o);

  assert_disable_idle_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_enable_i |=> !busy_o);
endmodule

bind spi_inhibit_master spi_inhibit_master_chk #(.NUM_SS(NUM_SS)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ctrl_enable_i  (ctrl_enable_i),
  .ctrl_inhibit_i (ctrl_inhibit_i),
  .ctrl_cpol_i    (ctrl_cpol_i),
  .ss_vec_i       (ss_vec_i),
  .rx_rd_i        (rx_rd_i),
  .sck_o          (sck_o),
  .mosi_o         (mosi_o),
  .ss_no          (ss_no),
  .busy_o         (busy_o),
  .status_o       (status_o),
  .irq_o          (irq_o)
);

// File: tb/test_spi_inhibit_master.sv
`timescale 1ns/1ps
module test_spi_inhibit_master;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en = 1'b0, inh = 1'b0, man = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [7:0] div = 8'd2;
  logic [3:0] ss_vec = 4'hF;
  logic [7:0] tx_data = 8'h00;
  logic       tx_wr = 1'b0, rx_rd = 1'b0;
  logic [1:0] irq_clr = 2'b00;
  logic       miso = 1'b0;
  logic       sck, mosi, busy;
  logic [3:0] ss_no, status;
  logic [7:0] rx_data;
  logic [1:0] irq;

  always #2.5 clk = ~clk;

  spi_inhibit_master i_spi_inhibit_master (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_enable_i(en), .ctrl_inhibit_i(inh),
    .ctrl_manual_ss_i(man), .ctrl_cpol_i(cpol), .ctrl_cpha_i(cpha), .div_i(div),
    .ss_vec_i(ss_vec), .tx_data_i(tx_data), .tx_wr_i(tx_wr), .rx_rd_i(rx_rd),
    .irq_clr_i(irq_clr), .miso_i(miso), .sck_o(sck), .mosi_o(mosi), .ss_no(ss_no),
    .rx_data_o(rx_data), .busy_o(busy), .status_o(status), .irq_o(irq));

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // behavioural slave
  logic [7:0] slv_tx = 8'h00, slv_sh = 8'h00, slv_rx = 8'h00;
  int slv_edges = 0;
  always @(posedge busy) begin
    slv_sh = slv_tx; slv_edges = 0; miso = slv_tx[7];
  end
  always @(sck) begin
    if (!(&ss_no) && slv_edges < 16) begin
      slv_edges++;
      if (!cpha) begin
        if (slv_edges % 2 == 1) slv_rx = {slv_rx[6:0], mosi};
        else begin slv_sh = slv_sh << 1; miso = slv_sh[7]; end
      end else begin
        if (slv_edges % 2 == 1) begin
          if (slv_edges > 1) slv_sh = slv_sh << 1;
          miso = slv_sh[7];
        end else slv_rx = {slv_rx[6:0], mosi};
      end
    end
  end

  // scoreboard
  typedef struct { logic [7:0] mtx; logic [7:0] stx; } exp_t;
  exp_t sb_q[$];
  int exp_half = 2;
  bit abort_exp = 0;

  task automatic push_exp(input logic [7:0] m, input logic [7:0] s);
    exp_t e;
    e.mtx = m; e.stx = s;
    slv_tx = s;
    sb_q.push_back(e);
  endtask

  int nc = 0, n_start = 0, n_first = -1, n_last = 0, n_done = 0, n_ss = 0, n_edges = 0;
  logic busy_p = 1'b0, sck_p = 1'b0;
  logic [3:0] ss_p = 4'hF;

  always @(negedge clk) begin
    nc++;
    if (busy && !busy_p) begin
      n_start = nc; n_edges = 0; n_first = -1;
    end
    if (sck != sck_p && busy_p) begin
      n_edges++;
      if (n_first < 0) n_first = nc;
      n_last = nc;
    end
    if (!busy && busy_p) begin
      n_done = nc;
      if (!abort_exp) begin
        if (sb_q.size() == 0) chk(0, "R4", "unexpected completion", 0, 1);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(rx_data == e.stx, "R4", "rx_data_o", rx_data, e.stx);
          chk(slv_rx == e.mtx, "R4", "slave saw mosi byte", slv_rx, e.mtx);
          chk(status == 4'b0110, "R9", "status at completion", status, 4'b0110);
          chk(irq == 2'b11, "R9", "irq at completion", irq, 2'b11);
          chk(n_edges == 16, "R5", "sck edge count", n_edges, 16);
          chk(n_first - n_start == exp_half, "R6", "lead select to first edge",
              n_first - n_start, exp_half);
          chk(n_done - n_last == (cpha ? exp_half : 0), "R8", "last edge to completion",
              n_done - n_last, cpha ? exp_half : 0);
          chk(n_done - n_start == (cpha ? 17 : 16) * exp_half, "R12", "busy duration",
              n_done - n_start, (cpha ? 17 : 16) * exp_half);
        end
      end
    end
    if ((&ss_no) && !(&ss_p)) n_ss = nc;
    busy_p = busy; sck_p = sck; ss_p = ss_no;
  end

  task automatic write_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic rd_clear();
    @(negedge clk); rx_rd = 1'b1; irq_clr = 2'b11;
    @(negedge clk); rx_rd = 1'b0; irq_clr = 2'b00;
  endtask

  task automatic set_mode(input logic p, input logic h, input logic [7:0] d);
    @(negedge clk);
    cpol = p; cpha = h; div = d;
    exp_half = (d == 0) ? 1 : int'(d);
  endtask

  task automatic run_xfer(input logic [7:0] m, input logic [7:0] s);
    push_exp(m, s);
    write_tx(m);
    wait (busy);
    wait (!busy);
    repeat (exp_half + 3) @(negedge clk);
    if (!man) chk(n_ss - n_done == exp_half, "R6", "select tail after completion",
                  n_ss - n_done, exp_half);
    rd_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(status == 4'b0101, "R1", "reset status", status, 4'b0101);
    chk(irq == 2'b00, "R1", "reset irq", irq, 0);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
    chk(ss_no == 4'hF, "R1", "reset ss", ss_no, 4'hF);
    chk(sck == cpol, "R1", "reset sck", sck, cpol);

    // inhibit and ignored second write
    en = 1'b1; inh = 1'b1; ss_vec = 4'b1110;
    set_mode(1'b0, 1'b0, 8'd2);
    write_tx(8'hA5);
    chk(status == 4'b1001, "R3", "status after write", status, 4'b1001);
    write_tx(8'h3C);
    repeat (50) @(negedge clk);
    chk(busy == 1'b0, "R2", "busy while inhibited", busy, 0);
    chk(ss_no == 4'hF, "R2", "ss while inhibited", ss_no, 4'hF);
    chk(sck == 1'b0, "R2", "sck while inhibited", sck, 0);
    push_exp(8'hA5, 8'h5C);
    @(negedge clk); inh = 1'b0;
    wait (busy);
    wait (!busy);
    repeat (exp_half + 3) @(negedge clk);
    chk(n_ss - n_done == exp_half, "R6", "select tail", n_ss - n_done, exp_half);
    chk(status == 4'b0110, "R3", "stored byte sent, tx empty", status, 4'b0110);

    // R10 flag clears
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    chk(status == 4'b0101, "R10", "status after read", status, 4'b0101);
    @(negedge clk); irq_clr = 2'b01;
    @(negedge clk); irq_clr = 2'b00;
    chk(irq == 2'b10, "R10", "irq after clearing bit0", irq, 2'b10);
    rd_clear();
    chk(irq == 2'b00, "R10", "irq after clearing all", irq, 0);

    // all modes, several dividers
    set_mode(1'b0, 1'b1, 8'd3); run_xfer(8'h3C, 8'hC3);
    set_mode(1'b1, 1'b0, 8'd0); run_xfer(8'h81, 8'h7E);
    chk(sck == 1'b1, "R4", "sck idles high with cpol 1", sck, 1);
    set_mode(1'b1, 1'b1, 8'd1); run_xfer(8'hF0, 8'h0F);
    set_mode(1'b1, 1'b0, 8'd5); run_xfer(8'h55, 8'hAA);
    set_mode(1'b0, 1'b0, 8'd1); run_xfer(8'h01, 8'h80);

    // manual select
    set_mode(1'b0, 1'b1, 8'd2);
    @(negedge clk); man = 1'b1; ss_vec = 4'b1011;
    @(negedge clk);
    chk(ss_no == 4'b1011 && !busy, "R7", "manual ss while idle", ss_no, 4'b1011);
    run_xfer(8'hC6, 8'h39);
    chk(ss_no == 4'b1011, "R7", "manual ss held between bytes", ss_no, 4'b1011);
    run_xfer(8'h2D, 8'hD2);
    repeat (10) @(negedge clk);
    chk(ss_no == 4'b1011, "R7", "manual ss held after bytes", ss_no, 4'b1011);
    ss_vec = 4'hF; @(negedge clk);
    chk(ss_no == 4'hF, "R7", "manual ss released", ss_no, 4'hF);
    man = 1'b0;

    // abort by releasing all selects
    set_mode(1'b0, 1'b0, 8'd4);
    ss_vec = 4'b1110; abort_exp = 1;
    write_tx(8'h96);
    wait (busy);
    repeat (21) @(negedge clk);
    ss_vec = 4'hF;
    @(negedge clk); @(negedge clk);
    chk(busy == 1'b0, "R11", "busy after abort", busy, 0);
    chk(sck == 1'b0, "R11", "sck idle after abort", sck, 0);
    chk(status == 4'b1001, "R11", "status unchanged by abort", status, 4'b1001);
    chk(irq == 2'b00, "R11", "irq unchanged by abort", irq, 0);
    abort_exp = 0;
    push_exp(8'h96, 8'h5A);
    ss_vec = 4'b1110;
    wait (busy); wait (!busy);
    @(negedge clk);
    chk(rx_data == 8'h5A, "R11", "restarted byte received whole", rx_data, 8'h5A);
    chk(slv_rx == 8'h96, "R11", "restarted byte sent whole", slv_rx, 8'h96);
    repeat (exp_half + 3) @(negedge clk);
    rd_clear();

    // abort by disable
    set_mode(1'b1, 1'b1, 8'd2);
    abort_exp = 1;
    write_tx(8'h3E);
    wait (busy);
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(busy == 1'b0, "R13", "busy after disable", busy, 0);
    chk(ss_no == 4'hF, "R13", "ss high while disabled", ss_no, 4'hF);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R13", "no start while disabled", busy, 0);
    abort_exp = 0;
    push_exp(8'h3E, 8'h99);
    en = 1'b1;
    wait (busy); wait (!busy);
    @(negedge clk);
    chk(rx_data == 8'h99, "R13", "byte after re-enable", rx_data, 8'h99);
    repeat (exp_half + 3) @(negedge clk);
    rd_clear();

    chk(sb_q.size() == 0, "R9", "all expected bytes completed", sb_q.size(), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule